// File: doc/BRIEF.md
# Reset Cause Supervisor

This block merges every reset cause of a small controller into one internal reset and keeps three sticky status flags that software reads and writes: a power-off flag, a low-supply flag and an oscillator-failure flag. The causes are a power-on detect pulse, a low-supply comparator level, an oscillator-failure level, an active-low external reset pin and a watchdog expiry pulse. The analog detectors are outside the block and arrive as digital inputs.

Low supply and oscillator failure always raise their flags. Each of them forces a reset only when its own reset enable is set. The flags are not touched by the internal reset they cause, so software can read them after restart and learn why the device restarted. The enables sit behind a shadow register, and a new value only takes effect after a two-write unlock sequence. This keeps a stray write from switching off a safety reset. The internal reset is stretched for a fixed number of clocks after its last active cause goes away. The external pin is ignored unless it is held low long enough.

The power-on detect pulse is the block's own synchronous active-high reset. The asynchronous levels pass through a flop synchronizer before they are used.

Top module: `reset_supervisor`

## Requirements
- R1: While `por_i` is 1, the block loads power-off flag 1, low-supply flag 0 and oscillator flag 0, sets both reset enables to 1, and asserts `rst_int_o`.
- R2: After the synchronizer delay (`SYNC_STAGES` clocks), every clock in which `lowv_i` is seen high sets the low-supply flag, whatever the enable says. This set wins over a software clear in the same clock.
- R3: A synchronized low supply asserts `rst_int_o` on the next clock when the low-supply reset enable is 1, and never asserts it when that enable is 0.
- R4: A synchronized `oscfail_i` sets the oscillator flag every time. It asserts `rst_int_o` on the next clock only when the oscillator reset enable is 1.
- R5: A software write to address 0 loads the flags from data bit 0 (power-off), bit 1 (low-supply) and bit 2 (oscillator), so software can both set and clear each flag. Every software write is ignored while `rst_int_o` is 1.
- R6: A write to address 1 loads only the shadow enables: bit 0 is the low-supply enable and bit 1 is the oscillator enable. The active enables take the shadow value only when A5h is written to address 2 and the very next write is 5Ah to address 3. Any other write in between, or any other value, voids the sequence.
- R7: An internal reset from any cause other than power-on restores both active and shadow enables to 1 and discards a half-done unlock sequence. It leaves all three flags unchanged.
- R8: `ext_rst_n_i` held low for at least `EXT_MIN_CYCLES` (24) consecutive clocks causes an internal reset. Any shorter low pulse has no effect.
- R9: A one-clock `wdt_expire_i` pulse asserts `rst_int_o` on the next clock.
- R10: `rst_int_o` stays 1 for `HOLD_CYCLES` clocks after the last clock edge at which any cause was active, then falls to 0 on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_i | input | 1 | Power-on detect pulse, synchronous active-high reset of the block |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| lowv_i | input | 1 | Low-supply comparator level, asynchronous |
| oscfail_i | input | 1 | Oscillator-failure level, asynchronous |
| wdt_expire_i | input | 1 | Watchdog expiry pulse, synchronous |
| sw_wr_i | input | 1 | Software write strobe |
| sw_addr_i | input | 2 | Write address: 0 flags, 1 shadow enables, 2 and 3 unlock keys |
| sw_wdata_i | input | DATA_W | Write data |
| rst_int_o | output | 1 | Internal reset, active high |
| pof_o | output | 1 | Power-off flag |
| lvf_o | output | 1 | Low-supply flag |
| osf_o | output | 1 | Oscillator-failure flag |
| lvr_en_o | output | 1 | Active low-supply reset enable |
| ofr_en_o | output | 1 | Active oscillator reset enable |

## Verification
The bench drives an external pulse of 23 clocks and then one of 24 clocks. A qualifier with an off-by-one error would either reset on the short pulse or miss the long one. It writes an unlock sequence that another write breaks, one with a wrong key, and a shadow write made during reset followed by an unlock; an enable that commits early, or a shadow that survives reset, would show the wrong active enables. It holds a low supply while software clears the flag and while the low-supply reset is disabled, which shows whether the hardware set wins and whether a disabled cause still resets. It also counts the exact clock on which reset is released and checks that the flags survive every non-power-on reset.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  localparam int RSUP_ADDR_W = 2;

  // software write map
  typedef enum logic [RSUP_ADDR_W-1:0] {
    REG_FLAGS  = 2'd0,
    REG_SHADOW = 2'd1,
    REG_KEY_A  = 2'd2,
    REG_KEY_B  = 2'd3
  } rsup_addr_e;

  // flag bit positions in a write to REG_FLAGS
  localparam int FLAG_POF = 0;
  localparam int FLAG_LVF = 1;
  localparam int FLAG_OSF = 2;

  // enable pair: lv is bit 0, osc is bit 1
  typedef struct packed {
    logic osc;
    logic lv;
  } rst_en_t;

  localparam int EN_W = $bits(rst_en_t);
  localparam rst_en_t RSUP_EN_RESET = '{osc: 1'b1, lv: 1'b1};

  // asynchronous input lanes through the synchronizer
  localparam int LANE_EXT = 0;
  localparam int LANE_LV  = 1;
  localparam int LANE_OSC = 2;
  localparam int N_LANES  = 3;

endpackage

// File: rtl/rsup_sync.sv
module rsup_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] pipe_q;
  logic [STAGES-1:0][WIDTH-1:0] pipe_d;

  generate
    if (STAGES == 1) begin : g_single
      assign pipe_d = d_i;
    end else begin : g_chain
      assign pipe_d = {pipe_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= pipe_d;
  end

  assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rsup_ext_qual.sv
module rsup_ext_qual #(
  parameter int MIN_CYCLES = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_low_i,
  output logic hit_o
);

  localparam int CW = $clog2(MIN_CYCLES + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(MIN_CYCLES);

  logic [CW-1:0] low_cnt_q;

  // count consecutive low samples, saturate at the qualifying length
  always_ff @(posedge clk) begin
    if (rst || !pin_low_i) low_cnt_q <= '0;
    else if (low_cnt_q != CNT_TOP) low_cnt_q <= low_cnt_q + CW'(1);
  end

  assign hit_o = (low_cnt_q == CNT_TOP);

endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic por,
  input  logic src_i,
  output logic rst_o
);

  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(HOLD_CYCLES);

  logic [HW-1:0] hold_q;
  logic          rst_q;

  always_ff @(posedge clk) begin
    if (por || src_i) begin
      hold_q <= HOLD_LOAD;
      rst_q  <= 1'b1;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - HW'(1);
      rst_q  <= 1'b1;
    end else begin
      rst_q  <= 1'b0;
    end
  end

  assign rst_o = rst_q;

endmodule

// File: rtl/rsup_regs.sv
module rsup_regs
  import rsup_pkg::*;
#(
  parameter int                DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY_A  = 8'hA5,
  parameter logic [DATA_W-1:0] KEY_B  = 8'h5A
) (
  input  logic                   clk,
  input  logic                   por,
  input  logic                   rst_int,
  input  logic                   lv_evt,
  input  logic                   osc_evt,
  input  logic                   wr_en,
  input  logic [RSUP_ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  output logic                   pof_o,
  output logic                   lvf_o,
  output logic                   osf_o,
  output rst_en_t                en_o
);

  logic    wr_ok;
  logic    hit_flags, hit_shadow, hit_key_a, hit_key_b;
  logic    key_a_ok, key_b_ok;
  logic    pof_q, lvf_q, osf_q;
  logic    pof_d, lvf_d, osf_d;
  rst_en_t en_q, shadow_q;
  logic    armed_q;

  assign wr_ok      = wr_en & ~rst_int;
  assign hit_flags  = wr_ok && (wr_addr == REG_FLAGS);
  assign hit_shadow = wr_ok && (wr_addr == REG_SHADOW);
  assign hit_key_a  = wr_ok && (wr_addr == REG_KEY_A);
  assign hit_key_b  = wr_ok && (wr_addr == REG_KEY_B);
  assign key_a_ok   = hit_key_a && (wr_data == KEY_A);
  assign key_b_ok   = hit_key_b && (wr_data == KEY_B) && armed_q;

  // flag next state: software load first, hardware set on top
  always_comb begin
    pof_d = pof_q;
    lvf_d = lvf_q;
    osf_d = osf_q;
    if (hit_flags) begin
      pof_d = wr_data[FLAG_POF];
      lvf_d = wr_data[FLAG_LVF];
      osf_d = wr_data[FLAG_OSF];
    end
    if (lv_evt)  lvf_d = 1'b1;
    if (osc_evt) osf_d = 1'b1;
  end

  // flags answer only to power-on, never to the internal reset
  always_ff @(posedge clk) begin
    if (por) begin
      pof_q <= 1'b1;
      lvf_q <= 1'b0;
      osf_q <= 1'b0;
    end else begin
      pof_q <= pof_d;
      lvf_q <= lvf_d;
      osf_q <= osf_d;
    end
  end

  // enables: shadow plus two-key commit, restored by any reset
  always_ff @(posedge clk) begin
    if (por || rst_int) begin
      en_q     <= RSUP_EN_RESET;
      shadow_q <= RSUP_EN_RESET;
      armed_q  <= 1'b0;
    end else begin
      if (wr_ok)      armed_q  <= key_a_ok;
      if (hit_shadow) shadow_q <= rst_en_t'(wr_data[EN_W-1:0]);
      if (key_b_ok)   en_q     <= shadow_q;
    end
  end

  assign pof_o = pof_q;
  assign lvf_o = lvf_q;
  assign osf_o = osf_q;
  assign en_o  = en_q;

endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import rsup_pkg::*;
#(
  parameter int                SYNC_STAGES    = 2,
  parameter int                EXT_MIN_CYCLES = 24,
  parameter int                HOLD_CYCLES    = 16,
  parameter int                DATA_W         = 8,
  parameter logic [DATA_W-1:0] FEED_KEY_A     = 8'hA5,
  parameter logic [DATA_W-1:0] FEED_KEY_B     = 8'h5A
) (
  input  logic                   clk,
  input  logic                   por_i,
  input  logic                   ext_rst_n_i,
  input  logic                   lowv_i,
  input  logic                   oscfail_i,
  input  logic                   wdt_expire_i,
  input  logic                   sw_wr_i,
  input  logic [RSUP_ADDR_W-1:0] sw_addr_i,
  input  logic [DATA_W-1:0]      sw_wdata_i,
  output logic                   rst_int_o,
  output logic                   pof_o,
  output logic                   lvf_o,
  output logic                   osf_o,
  output logic                   lvr_en_o,
  output logic                   ofr_en_o
);

  logic [N_LANES-1:0] raw_lanes;
  logic [N_LANES-1:0] sync_lanes;
  logic               ext_low;
  logic               lv_sync;
  logic               osc_sync;
  logic               ext_hit;
  logic               rst_src;
  logic               rst_int;
  rst_en_t            en;

  always_comb begin
    raw_lanes           = '0;
    raw_lanes[LANE_EXT] = ~ext_rst_n_i;
    raw_lanes[LANE_LV]  = lowv_i;
    raw_lanes[LANE_OSC] = oscfail_i;
  end

  rsup_sync #(
    .WIDTH  (N_LANES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (por_i),
    .d_i (raw_lanes),
    .q_o (sync_lanes)
  );

  assign ext_low  = sync_lanes[LANE_EXT];
  assign lv_sync  = sync_lanes[LANE_LV];
  assign osc_sync = sync_lanes[LANE_OSC];

  rsup_ext_qual #(
    .MIN_CYCLES (EXT_MIN_CYCLES)
  ) u_ext_qual (
    .clk       (clk),
    .rst       (por_i),
    .pin_low_i (ext_low),
    .hit_o     (ext_hit)
  );

  assign rst_src = ext_hit
                 | (lv_sync  & en.lv)
                 | (osc_sync & en.osc)
                 | wdt_expire_i;

  rsup_stretch #(
    .HOLD_CYCLES (HOLD_CYCLES)
  ) u_stretch (
    .clk   (clk),
    .por   (por_i),
    .src_i (rst_src),
    .rst_o (rst_int)
  );

  rsup_regs #(
    .DATA_W (DATA_W),
    .KEY_A  (FEED_KEY_A),
    .KEY_B  (FEED_KEY_B)
  ) u_regs (
    .clk     (clk),
    .por     (por_i),
    .rst_int (rst_int),
    .lv_evt  (lv_sync),
    .osc_evt (osc_sync),
    .wr_en   (sw_wr_i),
    .wr_addr (sw_addr_i),
    .wr_data (sw_wdata_i),
    .pof_o   (pof_o),
    .lvf_o   (lvf_o),
    .osf_o   (osf_o),
    .en_o    (en)
  );

  assign rst_int_o = rst_int;
  assign lvr_en_o  = en.lv;
  assign ofr_en_o  = en.osc;

endmodule

// File: rtl/rsup_checker.sv
module rsup_checker
  import rsup_pkg::*;
(
  input logic                   clk,
  input logic                   por_i,
  input logic                   lv_sync,
  input logic                   osc_sync,
  input logic                   wdt_expire_i,
  input logic                   sw_wr_i,
  input logic [RSUP_ADDR_W-1:0] sw_addr_i,
  input logic                   sw_pof_bit,
  input logic                   rst_int_o,
  input logic                   pof_o,
  input logic                   lvf_o,
  input logic                   osf_o,
  input logic                   lvr_en_o,
  input logic                   ofr_en_o
);

  AST_LV_FLAG_SET: assert property (@(posedge clk) disable iff (por_i)
    lv_sync |=> lvf_o);  // R2

  AST_LV_RESET: assert property (@(posedge clk) disable iff (por_i)
    (lv_sync && lvr_en_o) |=> rst_int_o);  // R3

  AST_OSC_FLAG_SET: assert property (@(posedge clk) disable iff (por_i)
    osc_sync |=> osf_o);  // R4

  AST_OSC_RESET: assert property (@(posedge clk) disable iff (por_i)
    (osc_sync && ofr_en_o) |=> rst_int_o);  // R4

  AST_POF_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (por_i)
    $fell(pof_o) |-> $past(sw_wr_i && (sw_addr_i == REG_FLAGS) && !sw_pof_bit && !rst_int_o));  // R5

  AST_EN_CHANGE_CAUSE: assert property (@(posedge clk) disable iff (por_i)
    !$stable({lvr_en_o, ofr_en_o}) |-> $past(rst_int_o || (sw_wr_i && (sw_addr_i == REG_KEY_B))));  // R6

  AST_FLAGS_HELD_IN_RESET: assert property (@(posedge clk) disable iff (por_i)
    (rst_int_o && !lv_sync && !osc_sync) |=> $stable({pof_o, lvf_o, osf_o}));  // R7

  AST_WDT_RESET: assert property (@(posedge clk) disable iff (por_i)
    wdt_expire_i |=> rst_int_o);  // R9

endmodule

bind reset_supervisor rsup_checker i_rsup_checker (
  .clk          (clk),
  .por_i        (por_i),
  .lv_sync      (lv_sync),
  .osc_sync     (osc_sync),
  .wdt_expire_i (wdt_expire_i),
  .sw_wr_i      (sw_wr_i),
  .sw_addr_i    (sw_addr_i),
  .sw_pof_bit   (sw_wdata_i[rsup_pkg::FLAG_POF]),
  .rst_int_o    (rst_int_o),
  .pof_o        (pof_o),
  .lvf_o        (lvf_o),
  .osf_o        (osf_o),
  .lvr_en_o     (lvr_en_o),
  .ofr_en_o     (ofr_en_o)
);

// File: tb/test_reset_supervisor.sv
module test_reset_supervisor;

  localparam int HOLD = 16;
  localparam int EXTN = 24;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       ext_n = 1'b1;
  logic       lowv = 1'b0;
  logic       oscf = 1'b0;
  logic       wdt = 1'b0;
  logic       sw_wr = 1'b0;
  logic [1:0] sw_addr = 2'd0;
  logic [7:0] sw_wdata = 8'd0;
  logic       rst_int, pof, lvf, osf, lvr, ofr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model of the software-visible state
  logic [2:0] m_flags;
  logic [1:0] m_shadow, m_en;
  logic       m_armed;

  always #2 clk = ~clk;

  reset_supervisor #(
    .HOLD_CYCLES    (HOLD),
    .EXT_MIN_CYCLES (EXTN)
  ) i_reset_supervisor (
    .clk          (clk),
    .por_i        (por),
    .ext_rst_n_i  (ext_n),
    .lowv_i       (lowv),
    .oscfail_i    (oscf),
    .wdt_expire_i (wdt),
    .sw_wr_i      (sw_wr),
    .sw_addr_i    (sw_addr),
    .sw_wdata_i   (sw_wdata),
    .rst_int_o    (rst_int),
    .pof_o        (pof),
    .lvf_o        (lvf),
    .osf_o        (osf),
    .lvr_en_o     (lvr),
    .ofr_en_o     (ofr)
  );

  function automatic logic [4:0] st();
    return {pof, lvf, osf, lvr, ofr};
  endfunction

  function automatic logic [4:0] exp_status(input logic [2:0] f, input logic [1:0] e);
    return {f[0], f[1], f[2], e[0], e[1]};
  endfunction

  function automatic logic next_armed(input logic [1:0] a, input logic [7:0] d);
    return (a == 2'd2) && (d == 8'hA5);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_write(input logic [1:0] a, input logic [7:0] d);
    sw_addr = a; sw_wdata = d; sw_wr = 1'b1;
    @(negedge clk);
    sw_wr = 1'b0;
  endtask

  task automatic feed();
    sw_write(2'd2, 8'hA5);
    sw_write(2'd3, 8'h5A);
  endtask

  task automatic watch_quiet(input int n, input string tag);
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (rst_int) seen = 1'b1;
    end
    chk(tag, {31'b0, seen}, 32'd0);
  endtask

  task automatic wait_release(input string tag);
    for (int i = 0; i < 200; i++) if (rst_int) @(negedge clk);
    chk(tag, {31'b0, rst_int}, 32'd0);
  endtask

  task automatic model_write(input logic [1:0] a, input logic [7:0] d);
    case (a)
      2'd0: m_flags = d[2:0];
      2'd1: m_shadow = d[1:0];
      2'd3: if (m_armed && d == 8'h5A) m_en = m_shadow;
      default: ;
    endcase
    m_armed = next_armed(a, d);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    tick(4);
    // R1 reset state and R10 release after power-on
    por = 1'b0;
    tick(HOLD);
    chk("R1 status after por", {27'b0, st()}, 32'b10011);
    chk("R10 reset still held", {31'b0, rst_int}, 32'd1);
    tick(1);
    chk("R10 reset released", {31'b0, rst_int}, 32'd0);

    // R5 software clears and sets flags
    sw_write(2'd0, 8'h00);
    chk("R5 clear all flags", {27'b0, st()}, 32'b00011);
    sw_write(2'd0, 8'h07);
    chk("R5 set all flags", {27'b0, st()}, 32'b11111);
    sw_write(2'd0, 8'h00);

    // R5 / R6 random writes against the model
    m_flags = 3'b000; m_shadow = 2'b11; m_en = 2'b11; m_armed = 1'b0;
    for (int i = 0; i < 300; i++) begin
      int unsigned r;
      logic [1:0] a;
      logic [7:0] d;
      r = $urandom;
      a = r[1:0];
      case (r[3:2])
        2'd0: d = 8'hA5;
        2'd1: d = 8'h5A;
        default: d = r[15:8];
      endcase
      sw_write(a, d);
      model_write(a, d);
      chk("R5/R6 random write", {27'b0, st()}, {27'b0, exp_status(m_flags, m_en)});
    end
    sw_write(2'd1, 8'h03);
    feed();
    sw_write(2'd0, 8'h00);
    chk("R6 restore enables", {27'b0, st()}, 32'b00011);

    // R2 and R3: low supply with reset enabled
    lowv = 1'b1; tick(3); lowv = 1'b0; tick(1);
    chk("R2 low flag set", {31'b0, lvf}, 32'd1);
    chk("R3 low supply resets when enabled", {31'b0, rst_int}, 32'd1);
    wait_release("R10 release after low supply");
    chk("R7 flag survives low reset", {27'b0, st()}, 32'b01011);

    // R6 commit only after keys, R3 disabled reset
    sw_write(2'd0, 8'h00);
    sw_write(2'd1, 8'h02);
    chk("R6 shadow write alone", {30'b0, lvr, ofr}, 32'b11);
    feed();
    chk("R6 commit after keys", {30'b0, lvr, ofr}, 32'b01);
    lowv = 1'b1; tick(3);
    sw_write(2'd0, 8'h00);
    chk("R2 hw set beats sw clear", {31'b0, lvf}, 32'd1);
    sw_write(2'd0, 8'h01);
    chk("R2 pof set lvf kept", {30'b0, pof, lvf}, 32'b11);
    lowv = 1'b0;
    watch_quiet(30, "R3 no reset when disabled");

    // R6 broken sequences
    sw_write(2'd1, 8'h03);
    sw_write(2'd2, 8'hA5);
    sw_write(2'd0, 8'h03);
    sw_write(2'd3, 8'h5A);
    chk("R6 interrupted sequence", {30'b0, lvr, ofr}, 32'b01);
    sw_write(2'd2, 8'hA4);
    sw_write(2'd3, 8'h5A);
    chk("R6 wrong key", {30'b0, lvr, ofr}, 32'b01);
    feed();
    chk("R6 good sequence", {30'b0, lvr, ofr}, 32'b11);

    // R4 oscillator fail disabled then enabled
    sw_write(2'd1, 8'h01);
    feed();
    sw_write(2'd0, 8'h00);
    chk("R4 osc enable off", {30'b0, lvr, ofr}, 32'b10);
    oscf = 1'b1; tick(3); oscf = 1'b0;
    watch_quiet(30, "R4 no reset when disabled");
    chk("R4 osc flag set", {31'b0, osf}, 32'd1);
    sw_write(2'd1, 8'h03);
    feed();
    oscf = 1'b1; tick(3); oscf = 1'b0; tick(1);
    chk("R4 osc resets when enabled", {31'b0, rst_int}, 32'd1);
    wait_release("R10 release after osc");
    chk("R7 flags after osc reset", {27'b0, st()}, 32'b00111);

    // R9 and R10 watchdog pulse with exact release
    wdt = 1'b1; tick(1); wdt = 1'b0;
    chk("R9 watchdog reset", {31'b0, rst_int}, 32'd1);
    tick(HOLD);
    chk("R10 held after watchdog", {31'b0, rst_int}, 32'd1);
    tick(1);
    chk("R10 released after watchdog", {31'b0, rst_int}, 32'd0);

    // R7 reset restores enables and shadow; R5 writes ignored in reset
    sw_write(2'd0, 8'h07);
    sw_write(2'd1, 8'h00);
    feed();
    chk("R6 both enables off", {30'b0, lvr, ofr}, 32'b00);
    sw_write(2'd1, 8'h00);
    wdt = 1'b1; tick(1); wdt = 1'b0;
    sw_write(2'd0, 8'h00);
    sw_write(2'd1, 8'h00);
    wait_release("R9 release");
    chk("R5 write ignored in reset", {29'b0, pof, lvf, osf}, 32'b111);
    chk("R7 enables restored", {30'b0, lvr, ofr}, 32'b11);
    feed();
    chk("R7 shadow restored", {30'b0, lvr, ofr}, 32'b11);

    // R8 external pin length qualification
    ext_n = 1'b0; tick(EXTN - 1); ext_n = 1'b1;
    watch_quiet(40, "R8 short pulse ignored");
    ext_n = 1'b0; tick(EXTN); ext_n = 1'b1;
    begin
      logic seen;
      seen = 1'b0;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (rst_int) seen = 1'b1;
      end
      chk("R8 long pulse resets", {31'b0, seen}, 32'd1);
    end
    wait_release("R8 release");
    chk("R7 flags after ext reset", {29'b0, pof, lvf, osf}, 32'b111);

    // R1 power-on again clears failure flags
    sw_write(2'd1, 8'h00);
    feed();
    por = 1'b1; tick(2); por = 1'b0; tick(1);
    chk("R1 status after second por", {27'b0, st()}, 32'b10011);
    chk("R1 reset asserted", {31'b0, rst_int}, 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1-flow watchdog expired: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule